// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block is a small bank of hardware lock flags that two independent ports, called left and right, share. A port takes part in a lock operation only when its flag select is high and its memory select is low. The lock protocol has three steps. A port asks for a flag by writing a zero in data bit 0. It then reads the flag to learn whether it holds it. When it is done, it writes a one to give the flag back. The low address bits choose which flag an access touches.

Every flag has a request latch for each port and one owner. A request made while the other port holds the flag waits, and the waiting port takes the flag at the same clock edge that frees it. When both ports ask for a free flag at the same edge, only one of them wins. Read data is registered. It is the same on every bit, so the upper and lower bytes always agree.

Top module: `two_port_sem_bank`

## Requirements
- R1: After reset every flag is free and both read data outputs are all ones.
- R2: An access happens only when sem_en is 1 and mem_en is 0. Any other combination, including both selects high, changes no flag, no request and no read data.
- R3: A write with wbit = 0 latches that port's request for the addressed flag. If the flag is free, the port owns it after that clock edge, and its later reads of the flag return all zeros.
- R4: While one port owns a flag, the other port reads that flag as all ones.
- R5: A read (wr = 0) loads rdata at the clock edge. The value comes from the flag state before that edge and fills all DATA_W bits, upper and lower byte alike. rdata holds its value until the next read by the same port.
- R6: A write with wbit = 1 clears the writing port's request latch. Ownership is released only if that port is the owner. A write of one by the port that does not own the flag leaves the owner unchanged.
- R7: A request that waits while the other port owns the flag is granted at the clock edge where the owner releases it.
- R8: When both ports request a free flag at the same edge, the left port gets it and the right request stays pending.
- R9: The address (flag index 0 to 7) selects one flag. Accesses to one flag never change any other flag.
- R10: A released flag with no pending request reads as all ones from both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_sem_en | input | 1 | Left flag select |
| lt_mem_en | input | 1 | Left memory select; must be 0 for a flag access |
| lt_wr | input | 1 | Left write (1) or read (0) |
| lt_addr | input | 3 | Left flag index |
| lt_wbit | input | 1 | Left write data bit 0: 0 request, 1 release |
| lt_rdata | output | 16 | Left read data, all bits equal |
| rt_sem_en | input | 1 | Right flag select |
| rt_mem_en | input | 1 | Right memory select; must be 0 for a flag access |
| rt_wr | input | 1 | Right write (1) or read (0) |
| rt_addr | input | 3 | Right flag index |
| rt_wbit | input | 1 | Right write data bit 0: 0 request, 1 release |
| rt_rdata | output | 16 | Right read data, all bits equal |

## Verification
The assertions assume that every input is synchronous to clk and stable through each clock edge. Both ports may hit the same flag in the same cycle, including with opposite write values. The bench drives all inputs at the falling edge and holds reset for several cycles before the first access. The random phase limits addresses to a few flags for part of the run, so that ties, waiting requests and handoffs happen often. It also mixes in the illegal combination of both selects high, at a low rate.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_LT   = 2'd1,
        OWN_RT   = 2'd2
    } owner_e;

    typedef struct packed {
        logic   req_lt;
        logic   req_rt;
        owner_e owner;
    } flag_state_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sem_en,
    input  logic                     mem_en,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wbit,
    output logic                     rd_en,
    output logic [(1<<ADDR_W)-1:0]   set_vec,
    output logic [(1<<ADDR_W)-1:0]   clr_vec
);
    localparam int NUM_FLAGS = 1 << ADDR_W;

    logic legal;

    always_comb begin
        legal   = sem_en && !mem_en;
        rd_en   = legal && !wr;
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            if (legal && wr && (addr == ADDR_W'(i))) begin
                set_vec[i] = !wbit;
                clr_vec[i] = wbit;
            end
        end
    end

    // One flag at most per write (R9)
    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec | clr_vec));

    // Illegal select combination produces no action (R2)
    assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_en && mem_en) |-> (!rd_en && (set_vec == '0) && (clr_vec == '0)));

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   set_lt,
    input  logic   clr_lt,
    input  logic   set_rt,
    input  logic   clr_rt,
    output owner_e owner
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_lt)      state_d.req_lt = 1'b1;
        else if (clr_lt) state_d.req_lt = 1'b0;
        if (set_rt)      state_d.req_rt = 1'b1;
        else if (clr_rt) state_d.req_rt = 1'b0;

        unique case (state_q.owner)
            OWN_LT: begin
                if (state_d.req_lt)      state_d.owner = OWN_LT;
                else if (state_d.req_rt) state_d.owner = OWN_RT;
                else                     state_d.owner = OWN_NONE;
            end
            OWN_RT: begin
                if (state_d.req_rt)      state_d.owner = OWN_RT;
                else if (state_d.req_lt) state_d.owner = OWN_LT;
                else                     state_d.owner = OWN_NONE;
            end
            default: begin
                if (state_d.req_lt)      state_d.owner = OWN_LT;
                else if (state_d.req_rt) state_d.owner = OWN_RT;
                else                     state_d.owner = OWN_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{req_lt: 1'b0, req_rt: 1'b0, owner: OWN_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    assign owner = state_q.owner;

    assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.owner == OWN_NONE && set_lt && set_rt) |=> (state_q.owner == OWN_LT));

    assert_keep_lt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.owner == OWN_LT && !clr_lt) |=> (state_q.owner == OWN_LT));

    assert_keep_rt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.owner == OWN_RT && !clr_rt) |=> (state_q.owner == OWN_RT));

    assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.owner == OWN_LT && clr_lt && state_q.req_rt && !clr_rt)
        |=> (state_q.owner == OWN_RT));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.owner == OWN_RT && clr_rt && !state_q.req_lt && !set_lt)
        |=> (state_q.owner == OWN_NONE));

endmodule

// File: rtl/two_port_sem_bank.sv
module two_port_sem_bank
    import sem_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_sem_en,
    input  logic              lt_mem_en,
    input  logic              lt_wr,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_wbit,
    output logic [DATA_W-1:0] lt_rdata,
    input  logic              rt_sem_en,
    input  logic              rt_mem_en,
    input  logic              rt_wr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_wbit,
    output logic [DATA_W-1:0] rt_rdata
);
    localparam int NUM_FLAGS = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] lt;
        logic [DATA_W-1:0] rt;
    } rd_state_t;

    logic                 lt_rd_en, rt_rd_en;
    logic [NUM_FLAGS-1:0] lt_set, lt_clr, rt_set, rt_clr;
    owner_e               owner_arr [NUM_FLAGS];
    rd_state_t            rd_d, rd_q;

    sem_port_decode #(.ADDR_W(ADDR_W)) u_dec_lt (
        .clk(clk), .rst_n(rst_n),
        .sem_en(lt_sem_en), .mem_en(lt_mem_en), .wr(lt_wr),
        .addr(lt_addr), .wbit(lt_wbit),
        .rd_en(lt_rd_en), .set_vec(lt_set), .clr_vec(lt_clr)
    );

    sem_port_decode #(.ADDR_W(ADDR_W)) u_dec_rt (
        .clk(clk), .rst_n(rst_n),
        .sem_en(rt_sem_en), .mem_en(rt_mem_en), .wr(rt_wr),
        .addr(rt_addr), .wbit(rt_wbit),
        .rd_en(rt_rd_en), .set_vec(rt_set), .clr_vec(rt_clr)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .set_lt(lt_set[g]), .clr_lt(lt_clr[g]),
            .set_rt(rt_set[g]), .clr_rt(rt_clr[g]),
            .owner(owner_arr[g])
        );
    end

    always_comb begin
        rd_d = rd_q;
        if (lt_rd_en) rd_d.lt = {DATA_W{owner_arr[lt_addr] != OWN_LT}};
        if (rt_rd_en) rd_d.rt = {DATA_W{owner_arr[rt_addr] != OWN_RT}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '{lt: '1, rt: '1};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign lt_rdata = rd_q.lt;
    assign rt_rdata = rd_q.rt;

    assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lt_rd_en |=> $stable(lt_rdata));

    assert_illegal_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_sem_en && rt_mem_en) |=> $stable(rt_rdata));

    assert_owner_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_rd_en && owner_arr[lt_addr] == OWN_LT) |=> (lt_rdata == '0));

    assert_other_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_rd_en && owner_arr[rt_addr] == OWN_LT) |=> (rt_rdata == '1));

endmodule

// File: tb/tb_two_port_sem_bank.sv
module tb_two_port_sem_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lt_sem_en = 0, lt_mem_en = 0, lt_wr = 0, lt_wbit = 0;
    logic [2:0]  lt_addr = 0;
    logic        rt_sem_en = 0, rt_mem_en = 0, rt_wr = 0, rt_wbit = 0;
    logic [2:0]  rt_addr = 0;
    logic [15:0] lt_rdata, rt_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int own [8];
    bit rql [8];
    bit rqr [8];
    logic [15:0] exp_l, exp_r;

    always #2.5 clk = ~clk;

    two_port_sem_bank dut (
        .clk(clk), .rst_n(rst_n),
        .lt_sem_en(lt_sem_en), .lt_mem_en(lt_mem_en), .lt_wr(lt_wr),
        .lt_addr(lt_addr), .lt_wbit(lt_wbit), .lt_rdata(lt_rdata),
        .rt_sem_en(rt_sem_en), .rt_mem_en(rt_mem_en), .rt_wr(rt_wr),
        .rt_addr(rt_addr), .rt_wbit(rt_wbit), .rt_rdata(rt_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_step();
        bit la, ra;
        la = lt_sem_en && !lt_mem_en;
        ra = rt_sem_en && !rt_mem_en;
        if (la && !lt_wr) exp_l = (own[lt_addr] == 1) ? 16'h0000 : 16'hFFFF;
        if (ra && !rt_wr) exp_r = (own[rt_addr] == 2) ? 16'h0000 : 16'hFFFF;
        if (la && lt_wr) rql[lt_addr] = !lt_wbit;
        if (ra && rt_wr) rqr[rt_addr] = !rt_wbit;
        for (int i = 0; i < 8; i++) begin
            if (own[i] == 1 && rql[i]) own[i] = 1;
            else if (own[i] == 2 && rqr[i]) own[i] = 2;
            else if (own[i] == 2 && rql[i]) own[i] = 1;
            else if (own[i] == 1 && rqr[i]) own[i] = 2;
            else if (own[i] == 0 && rql[i]) own[i] = 1;
            else if (own[i] == 0 && rqr[i]) own[i] = 2;
            else own[i] = 0;
        end
    endfunction

    task automatic step(input string tag,
                        input bit ls, input bit lm, input bit lw, input int la, input bit lb,
                        input bit rs, input bit rm, input bit rw, input int ra, input bit rb);
        @(negedge clk);
        lt_sem_en = ls; lt_mem_en = lm; lt_wr = lw; lt_addr = 3'(la); lt_wbit = lb;
        rt_sem_en = rs; rt_mem_en = rm; rt_wr = rw; rt_addr = 3'(ra); rt_wbit = rb;
        @(posedge clk);
        model_step();
        #1;
        check({tag, " left"}, lt_rdata, exp_l);
        check({tag, " right"}, rt_rdata, exp_r);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin own[i] = 0; rql[i] = 0; rqr[i] = 0; end
        exp_l = 16'hFFFF; exp_r = 16'hFFFF;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset left", lt_rdata, 16'hFFFF);
        check("R1 reset right", rt_rdata, 16'hFFFF);
        @(negedge clk); rst_n = 1'b1;

        // R1/R10: free flags read as ones from both ports
        step("R1", 1,0,0,0,0, 1,0,0,0,0);
        // R3: left takes flag 3, reads zeros
        step("R3 req", 1,0,1,3,0, 0,0,0,0,0);
        step("R3 read", 1,0,0,3,0, 1,0,0,3,0);   // R4 right reads ones
        check("R3 left owns", lt_rdata, 16'h0000);
        check("R4 right sees ones", rt_rdata, 16'hFFFF);
        // R2: illegal release attempt by left on flag 3
        step("R2 illegal wr", 1,1,1,3,1, 0,0,0,0,0);
        step("R2 after", 1,0,0,3,0, 0,0,0,0,0);
        check("R2 flag kept", lt_rdata, 16'h0000);
        // R2: illegal request of flag 5, and right read with memory select only
        step("R2 illegal req", 1,1,1,5,0, 0,1,0,5,0);
        step("R2 rt req 5", 0,0,0,0,0, 1,0,1,5,0);
        step("R2 rt read 5", 0,0,0,0,0, 1,0,0,5,0);
        check("R2 right got 5", rt_rdata, 16'h0000);
        // R5: illegal read leaves rdata unchanged, idle holds
        step("R5 illegal rd", 1,1,0,0,0, 0,0,0,0,0);
        step("R5 idle", 0,0,0,0,0, 0,0,0,0,0);
        check("R5 hold", lt_rdata, 16'h0000);
        // R6: right writes one to flag 3 it does not own
        step("R6 nonowner rel", 0,0,0,0,0, 1,0,1,3,1);
        step("R6 read", 1,0,0,3,0, 0,0,0,0,0);
        check("R6 owner kept", lt_rdata, 16'h0000);
        // R7: right pending on 3, left releases, right takes it
        step("R7 pend", 0,0,0,0,0, 1,0,1,3,0);
        step("R7 pend rd", 0,0,0,0,0, 1,0,0,3,0);
        check("R7 pending ones", rt_rdata, 16'hFFFF);
        step("R7 release", 1,0,1,3,1, 0,0,0,0,0);
        step("R7 handoff rd", 1,0,0,3,0, 1,0,0,3,0);
        check("R7 right owns", rt_rdata, 16'h0000);
        check("R7 left ones", lt_rdata, 16'hFFFF);
        // R8: tie on flag 6
        step("R8 tie", 1,0,1,6,0, 1,0,1,6,0);
        step("R8 rd", 1,0,0,6,0, 1,0,0,6,0);
        check("R8 left wins", lt_rdata, 16'h0000);
        check("R8 right loses", rt_rdata, 16'hFFFF);
        // R9: untouched flag 7 free for both
        step("R9 rd7", 1,0,0,7,0, 1,0,0,7,0);
        check("R9 flag7 left", lt_rdata, 16'hFFFF);
        // R10: right releases 5 with no waiter, both read ones
        step("R10 rel", 0,0,0,0,0, 1,0,1,5,1);
        step("R10 rd", 1,0,0,5,0, 1,0,0,5,0);
        check("R10 left", lt_rdata, 16'hFFFF);
        check("R10 right", rt_rdata, 16'hFFFF);

        // Random phase (R5 model comparison every cycle)
        for (int n = 0; n < 4000; n++) begin
            int am;
            am = (n < 2000) ? 2 : 8;
            step("R5 random",
                 ($urandom % 4) != 0, ($urandom % 10) == 0, $urandom % 2, int'($urandom % am), $urandom % 2,
                 ($urandom % 4) != 0, ($urandom % 10) == 0, $urandom % 2, int'($urandom % am), $urandom % 2);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule